// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control of an integrating converter that works in two slopes. A conversion starts from a cleared integrator. The integrator first sums the unknown input for a fixed span of 2^N clocks. It then sums a reference of opposite sign while a counter advances once per clock. When the zero-crossing comparator reports that the integrator is no longer above zero, the counter value is captured as the result. That value is the ratio of input to reference, scaled by 2^N. It does not depend on the integrator's resistor or capacitor values, because the same integrator and the same clock serve both slopes.

The block has three states. `ST_IDLE` holds the integrator cleared. A `start` pulse takes it to `ST_RUNUP`, where the input is selected. When the run-up count ends it moves to `ST_RUNDOWN`, where the reference is selected. It returns to `ST_IDLE` when the comparator falls or when the run-down count reaches 2^N, whichever comes first. The second exit saturates the result and raises the overflow flag. The integrator, the comparator and the reference lie outside the block.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held, and after it is released, `integ_rst` is 1 and `sel_ref`, `done`, `overflow` and `result` are all 0.
- R2: A `start` seen in `ST_IDLE` releases `integ_rst` on the next clock and holds `sel_ref` at 0 (input selected) for exactly 2^N clock cycles.
- R3: Directly after run-up, `sel_ref` is 1 (reference selected) and the run-down counter starts at 0 and advances once per clock. `sel_ref` returns to 0 only in the cycle in which `done` is 1.
- R4: If `cmp_pos` is sampled at 0 in the run-down cycle whose count is k (k < 2^N), then on the next clock `result` = k, `overflow` = 0 and `done` = 1. For the same ratio of input to reference, the result is the same.
- R5: `done` is 1 for exactly one cycle per conversion. `result` and `overflow` keep their values until the next conversion completes.
- R6: If the run-down count reaches 2^N, the conversion ends at that cycle whatever `cmp_pos` shows. `result` becomes all ones and `overflow` becomes 1.
- R7: A conversion that ends on the comparator clears an `overflow` flag left by an earlier one.
- R8: `start` has no effect in `ST_RUNUP` or `ST_RUNDOWN`. The run-up length, the run-down length and the result stay unchanged.
- R9: Once a conversion has completed, `integ_rst` is 1 again and `sel_ref` is 0, in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when the block is idle |
| cmp_pos | input | 1 | Comparator output, 1 while the integrator is above zero |
| sel_ref | output | 1 | Integrator input switch: 0 selects the input, 1 selects the reference |
| integ_rst | output | 1 | Integrator clear (auto-zero), active high |
| result | output | N | Latched run-down count |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Last conversion timed out and saturated |

## Verification
A behavioural integrator in the bench adds the input value on each run-up clock and subtracts the reference on each run-down clock, and it drives `cmp_pos` from the sign of its total.

- A zero input must give a count of 0, which catches an off-by-one at the start of run-down.
- An exact ratio gives 80.
- A fractional ratio must round up to 180, which shows that the comparator is sampled in the correct cycle.
- A full-scale ratio gives 255.
- An input equal to the reference lands exactly on the time-out boundary and must saturate.
- Two different input and reference pairs with the same ratio must give the same count.
- An overflow followed by a normal conversion shows that the overflow flag clears.
- `start` pulses placed inside both phases must leave both phase lengths and the result unchanged.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUNUP    = 2'd1,
        ST_RUNDOWN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dsadc_cnt.sv
module dsadc_cnt #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [N-1:0] count_lo,
    output logic         runup_last,
    output logic         tmo_hit
);
    localparam int W = N + 1;
    localparam logic [W-1:0] RUNUP_END = {1'b0, {N{1'b1}}};
    localparam logic [W-1:0] TMO_END   = {1'b1, {N{1'b0}}};

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + W'(1);
        end
    end

    assign count_lo   = count[N-1:0];
    assign runup_last = (count == RUNUP_END);
    assign tmo_hit    = (count == TMO_END);

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmp_pos,
    input  logic runup_last,
    input  logic tmo_hit,
    output logic sel_ref,
    output logic integ_rst,
    output logic cnt_clr,
    output logic cnt_en,
    output logic latch,
    output logic sat
);
    seq_state_t state, state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (start) state_nxt = ST_RUNUP;
            ST_RUNUP:   if (runup_last) state_nxt = ST_RUNDOWN;
            ST_RUNDOWN: if (tmo_hit || !cmp_pos) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sel_ref   = 1'b0;
        integ_rst = 1'b0;
        cnt_clr   = 1'b0;
        cnt_en    = 1'b0;
        latch     = 1'b0;
        sat       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                integ_rst = 1'b1;
                cnt_clr   = 1'b1;
            end
            ST_RUNUP: begin
                cnt_en  = 1'b1;
                cnt_clr = runup_last;
            end
            ST_RUNDOWN: begin
                sel_ref = 1'b1;
                cnt_en  = 1'b1;
                if (tmo_hit) begin
                    latch = 1'b1;
                    sat   = 1'b1;
                end else if (!cmp_pos) begin
                    latch = 1'b1;
                end
            end
            default: integ_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch,
    input  logic         sat,
    input  logic [N-1:0] count_lo,
    output logic [N-1:0] result,
    output logic         done,
    output logic         overflow
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            done     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            done <= latch;
            if (latch) begin
                result   <= sat ? {N{1'b1}} : count_lo;
                overflow <= sat;
            end
        end
    end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_pos,
    output logic         sel_ref,
    output logic         integ_rst,
    output logic [N-1:0] result,
    output logic         done,
    output logic         overflow
);
    logic         cnt_clr, cnt_en, runup_last, tmo_hit, latch, sat;
    logic [N-1:0] count_lo;

    dsadc_cnt #(.N(N)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
        .count_lo(count_lo), .runup_last(runup_last), .tmo_hit(tmo_hit)
    );

    dsadc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_pos(cmp_pos),
        .runup_last(runup_last), .tmo_hit(tmo_hit),
        .sel_ref(sel_ref), .integ_rst(integ_rst),
        .cnt_clr(cnt_clr), .cnt_en(cnt_en), .latch(latch), .sat(sat)
    );

    dsadc_result #(.N(N)) u_res (
        .clk(clk), .rst_n(rst_n), .latch(latch), .sat(sat),
        .count_lo(count_lo), .result(result), .done(done), .overflow(overflow)
    );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_ref,
    input logic         integ_rst,
    input logic [N-1:0] result,
    input logic         done,
    input logic         overflow
);
    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        integ_rst |-> !sel_ref);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(overflow)));

    // R6
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (result == {N{1'b1}}));

    // R3
    rundown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_ref) |-> done);

    // R2
    runup_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integ_rst) |-> !sel_ref);

endmodule

bind dsadc_seq dsadc_seq_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_ref(sel_ref), .integ_rst(integ_rst),
    .result(result), .done(done), .overflow(overflow)
);

// File: tb/test_dsadc_seq.sv
`timescale 1ns/1ps
module test_dsadc_seq;
    localparam int N     = 8;
    localparam int RUNUP = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_pos;
    logic         sel_ref, integ_rst, done, overflow;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;
    int vin_i = 0;
    int ref_i = 1;
    int acc = 0;

    always #5 clk = ~clk;

    // behavioural integrator and comparator
    always @(posedge clk) begin
        if (integ_rst)    acc <= 0;
        else if (sel_ref) acc <= acc - ref_i;
        else              acc <= acc + vin_i;
    end
    assign cmp_pos = (acc > 0);

    dsadc_seq #(.N(N)) i_dsadc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_pos(cmp_pos),
        .sel_ref(sel_ref), .integ_rst(integ_rst), .result(result),
        .done(done), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(integ_rst == 1'b1, "R1 integ_rst in reset", integ_rst, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(integ_rst == 1'b1, "R1 integ_rst idle", integ_rst, 1);
        chk(sel_ref == 1'b0, "R1 sel_ref idle", sel_ref, 0);
        chk(done == 1'b0, "R1 done idle", done, 0);
        chk(overflow == 1'b0, "R1 overflow idle", overflow, 0);
        chk(result == '0, "R1 result idle", result, 0);
    endtask

    task automatic run_conv(input int vin, input int refv, input bit glitch, input string tag);
        int  exp_k, exp_dn, exp_res, up_n, dn_n;
        bit  exp_ovf, seen;
        vin_i   = vin;
        ref_i   = refv;
        exp_k   = (vin * RUNUP + refv - 1) / refv;
        exp_ovf = (exp_k >= RUNUP);
        exp_dn  = exp_ovf ? RUNUP + 1 : exp_k + 1;
        exp_res = exp_ovf ? RUNUP - 1 : exp_k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0; up_n = 0; dn_n = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (!integ_rst && !sel_ref) up_n++;
            if (sel_ref) dn_n++;
            if (done) begin
                seen = 1'b1;
            end else begin
                start = glitch && (i == 40 || i == RUNUP + 20);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(seen, {"R4 done reached ", tag}, seen, 1);
        chk(up_n == RUNUP, {"R2 run-up length ", tag}, up_n, RUNUP);
        chk(dn_n == exp_dn, {"R3 run-down length ", tag}, dn_n, exp_dn);
        chk(result == N'(exp_res), {"R4/R6 result ", tag}, result, exp_res);
        chk(overflow == exp_ovf, {"R6/R7 overflow ", tag}, overflow, exp_ovf);
        chk(integ_rst == 1'b1 && sel_ref == 1'b0, {"R9 back to idle ", tag}, integ_rst, 1);
        if (glitch)
            chk(up_n == RUNUP && dn_n == exp_dn, {"R8 start ignored ", tag}, dn_n, exp_dn);
        @(negedge clk);
        chk(done == 1'b0, {"R5 done one cycle ", tag}, done, 0);
        repeat (4) @(negedge clk);
        chk(result == N'(exp_res) && done == 1'b0, {"R5 result held ", tag}, result, exp_res);
    endtask

    task automatic t_zero();       run_conv(0, 16, 1'b0, "zero input");        endtask
    task automatic t_exact();      run_conv(5, 16, 1'b0, "exact ratio");       endtask
    task automatic t_ratio();      run_conv(10, 32, 1'b0, "same ratio R4");    endtask
    task automatic t_fraction();   run_conv(7, 10, 1'b0, "rounds up");         endtask
    task automatic t_full();       run_conv(255, 256, 1'b0, "full scale");     endtask
    task automatic t_boundary();   run_conv(16, 16, 1'b0, "boundary R6");      endtask
    task automatic t_ovf_clear();
        run_conv(20, 16, 1'b0, "overflow R6");
        run_conv(3, 16, 1'b0, "clears R7");
    endtask
    task automatic t_start_ignored(); run_conv(7, 10, 1'b1, "start pulses R8"); endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_zero();
        t_exact();
        t_ratio();
        t_fraction();
        t_full();
        t_boundary();
        t_ovf_clear();
        t_start_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule